// File: doc/BRIEF.md
# Four-Window Overlay Compositor

This block sits in the pixel path of an on-screen display. On each clock it takes the character cell being drawn (row and column) and the pixel and line offset inside that cell. It decides whether the point lies in one of four rectangular background windows, or in the drop shadow of one of them. It returns a registered hit flag, a 3-bit RGB color and a shadow flag. The glyph renderer downstream places characters over this result.

Window bounds are given in whole character cells, and both bounds are inclusive. A window whose start exceeds its end on either axis is treated as absent. The shadow is the window rectangle shifted right by a coded number of pixels and down by a coded number of lines, with the window body removed, so it forms an L along the right and bottom edges. When windows overlap, the lowest-numbered window wins.

Each window holds an enable bit in a two-state machine with the states `WIN_OFF` and `WIN_ON`. The transition *load* moves a window to the state given by its bit of `en_value`. The transition *clear* forces every window to `WIN_OFF` at once, and clear takes precedence over load. With neither command the state holds.

Top module: `wincomp_top`

## Requirements
- R1: While reset is low, and after reset until an enable is loaded, `hit`, `rgb` and `in_shadow` are all 0, even for windows with valid bounds.
- R2: An enabled window with row start ≤ row end and column start ≤ column end covers every cell with row and column inside both inclusive bounds. On a covered cell `hit`=1, `rgb`=window color and `in_shadow`=0, one clock after the inputs are presented.
- R3: A window whose row start exceeds its row end, or whose column start exceeds its column end, produces neither body nor shadow, even when it is enabled.
- R4: Window 1 (index 0) has the highest priority and window 4 (index 3) the lowest. The highest-priority window whose body or shadow covers the point sets the output, even over a lower window's body.
- R5: Let X = column·12 + pixel offset and Y = row·18 + line offset. A shadow point is one inside the window rectangle shifted by +W in X and +H in Y, but not in the body. There `hit`=1, `rgb`=that window's shadow color and `in_shadow`=1.
- R6: Shadow width code 0,1,2,3 gives W = 2,4,6,8 pixels. Shadow height code 0,1,2,3 gives H = 2,4,6,8 lines.
- R7: With a window's shadow enable bit at 0, that window has no shadow.
- R8: A cycle with `en_clear`=1 puts all four windows in `WIN_OFF` from the next cycle on, whatever `en_load` and `en_value` hold.
- R9: A cycle with `en_load`=1 and `en_clear`=0 sets window i+1 on exactly when `en_value[i]`=1, from the next cycle on.
- R10: Where no window body or shadow covers the point, `hit`=0, `rgb`=000 and `in_shadow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_load | input | 1 | Load all enable bits from `en_value` |
| en_value | input | 4 | New enable bits, bit i for window i+1 |
| en_clear | input | 1 | Clear all enable bits; wins over load |
| row_idx | input | 5 | Current character row |
| col_idx | input | 5 | Current character column |
| px_off | input | 4 | Pixel offset inside the cell (0..11) |
| ln_off | input | 5 | Line offset inside the cell (0..17) |
| win_row_start | input | 20 | Row start per window, 5 bits each, window i at [5i+4:5i] |
| win_row_end | input | 20 | Row end per window |
| win_col_start | input | 20 | Column start per window |
| win_col_end | input | 20 | Column end per window |
| win_shd_en | input | 4 | Shadow enable per window |
| win_color | input | 12 | Body RGB per window, 3 bits each |
| shd_wcode | input | 8 | Shadow width code per window, 2 bits each |
| shd_hcode | input | 8 | Shadow height code per window, 2 bits each |
| shd_color | input | 12 | Shadow RGB per window, 3 bits each |
| hit | output | 1 | Point covered by a window body or shadow |
| rgb | output | 3 | Resulting color |
| in_shadow | output | 1 | Resulting color comes from a shadow |

## Verification
The assertions check on every cycle the parts that need no geometry. An uncovered point is black and not in shadow. The shadow flag implies a hit. Clear and load move the enable state machines as stated, and no hit appears while every window is off. The geometry can only be shown by the bench's directed scenarios: inclusive cell bounds, inverted bounds, the L-shaped shadow with its offset corners and coded extents, and the priority order when bodies and shadows overlap. The bench picks pixel coordinates on both sides of each edge to do this.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;

    typedef enum logic {
        WIN_OFF = 1'b0,
        WIN_ON  = 1'b1
    } win_state_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] rgb;
        logic       shd;
    } pix_res_t;

    // code 0..3 -> 2,4,6,8
    function automatic logic [3:0] shade_extent(input logic [1:0] code);
        return {1'b0, code, 1'b0} + 4'd2;
    endfunction

endpackage

// File: rtl/win_en_fsm.sv
module win_en_fsm
    import osd_win_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic value,
    input  logic clear,
    output logic is_on
);

    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OFF: if (clear) state_d = WIN_OFF;
                     else if (load && value) state_d = WIN_ON;
            WIN_ON:  if (clear) state_d = WIN_OFF;
                     else if (load && !value) state_d = WIN_OFF;
            default: state_d = WIN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_OFF;
        else        state_q <= state_d;
    end

    assign is_on = (state_q == WIN_ON);

endmodule

// File: rtl/win_region.sv
module win_region
    import osd_win_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 5,
    parameter int PX_W   = 4,
    parameter int LN_W   = 5,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18
) (
    input  logic [ROW_W-1:0] row_idx,
    input  logic [COL_W-1:0] col_idx,
    input  logic [PX_W-1:0]  px_off,
    input  logic [LN_W-1:0]  ln_off,
    input  logic [ROW_W-1:0] row_start,
    input  logic [ROW_W-1:0] row_end,
    input  logic [COL_W-1:0] col_start,
    input  logic [COL_W-1:0] col_end,
    input  logic             on,
    input  logic             shd_en,
    input  logic [1:0]       wcode,
    input  logic [1:0]       hcode,
    output logic             body,
    output logic             shade
);

    localparam int AX_W = COL_W + $clog2(CELL_W) + 2;
    localparam int AY_W = ROW_W + $clog2(CELL_H) + 2;

    logic [AX_W-1:0] ax, bx0, bx1, ew;
    logic [AY_W-1:0] ay, by0, by1, eh;
    logic            valid, in_bx, in_by, in_sx, in_sy;

    always_comb begin
        valid = on && (row_start <= row_end) && (col_start <= col_end);

        ax  = AX_W'(col_idx) * AX_W'(CELL_W) + AX_W'(px_off);
        ay  = AY_W'(row_idx) * AY_W'(CELL_H) + AY_W'(ln_off);
        bx0 = AX_W'(col_start) * AX_W'(CELL_W);
        bx1 = (AX_W'(col_end) + AX_W'(1)) * AX_W'(CELL_W) - AX_W'(1);
        by0 = AY_W'(row_start) * AY_W'(CELL_H);
        by1 = (AY_W'(row_end) + AY_W'(1)) * AY_W'(CELL_H) - AY_W'(1);
        ew  = AX_W'(shade_extent(wcode));
        eh  = AY_W'(shade_extent(hcode));

        in_bx = (ax >= bx0) && (ax <= bx1);
        in_by = (ay >= by0) && (ay <= by1);
        in_sx = (ax >= bx0 + ew) && (ax <= bx1 + ew);
        in_sy = (ay >= by0 + eh) && (ay <= by1 + eh);

        body  = valid && in_bx && in_by;
        shade = valid && shd_en && in_sx && in_sy && !body;
    end

endmodule

// File: rtl/win_priority.sv
module win_priority
    import osd_win_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int CLR_W = 3
) (
    input  logic [NWIN-1:0]       body,
    input  logic [NWIN-1:0]       shade,
    input  logic [NWIN*CLR_W-1:0] body_rgb,
    input  logic [NWIN*CLR_W-1:0] shade_rgb,
    output pix_res_t              res
);

    always_comb begin
        res = '0;
        // walk from lowest priority up so index 0 is applied last
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (body[i]) begin
                res.hit = 1'b1;
                res.rgb = body_rgb[i*CLR_W +: CLR_W];
                res.shd = 1'b0;
            end else if (shade[i]) begin
                res.hit = 1'b1;
                res.rgb = shade_rgb[i*CLR_W +: CLR_W];
                res.shd = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wincomp_top.sv
module wincomp_top
    import osd_win_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int ROW_W  = 5,
    parameter int COL_W  = 5,
    parameter int PX_W   = 4,
    parameter int LN_W   = 5,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_load,
    input  logic [NWIN-1:0]       en_value,
    input  logic                  en_clear,
    input  logic [ROW_W-1:0]      row_idx,
    input  logic [COL_W-1:0]      col_idx,
    input  logic [PX_W-1:0]       px_off,
    input  logic [LN_W-1:0]       ln_off,
    input  logic [NWIN*ROW_W-1:0] win_row_start,
    input  logic [NWIN*ROW_W-1:0] win_row_end,
    input  logic [NWIN*COL_W-1:0] win_col_start,
    input  logic [NWIN*COL_W-1:0] win_col_end,
    input  logic [NWIN-1:0]       win_shd_en,
    input  logic [NWIN*3-1:0]     win_color,
    input  logic [NWIN*2-1:0]     shd_wcode,
    input  logic [NWIN*2-1:0]     shd_hcode,
    input  logic [NWIN*3-1:0]     shd_color,
    output logic                  hit,
    output logic [2:0]            rgb,
    output logic                  in_shadow
);

    logic [NWIN-1:0] win_on, body, shade;
    pix_res_t        res_d, res_q;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        win_en_fsm u_en (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (en_load),
            .value (en_value[g]),
            .clear (en_clear),
            .is_on (win_on[g])
        );

        win_region #(
            .ROW_W(ROW_W), .COL_W(COL_W), .PX_W(PX_W), .LN_W(LN_W),
            .CELL_W(CELL_W), .CELL_H(CELL_H)
        ) u_reg (
            .row_idx   (row_idx),
            .col_idx   (col_idx),
            .px_off    (px_off),
            .ln_off    (ln_off),
            .row_start (win_row_start[g*ROW_W +: ROW_W]),
            .row_end   (win_row_end[g*ROW_W +: ROW_W]),
            .col_start (win_col_start[g*COL_W +: COL_W]),
            .col_end   (win_col_end[g*COL_W +: COL_W]),
            .on        (win_on[g]),
            .shd_en    (win_shd_en[g]),
            .wcode     (shd_wcode[g*2 +: 2]),
            .hcode     (shd_hcode[g*2 +: 2]),
            .body      (body[g]),
            .shade     (shade[g])
        );
    end

    win_priority #(.NWIN(NWIN), .CLR_W(3)) u_pri (
        .body      (body),
        .shade     (shade),
        .body_rgb  (win_color),
        .shade_rgb (shd_color),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit       = res_q.hit;
    assign rgb       = res_q.rgb;
    assign in_shadow = res_q.shd;

endmodule

// File: rtl/wincomp_chk.sv
module wincomp_chk #(
    parameter int NWIN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_load,
    input logic [NWIN-1:0] en_value,
    input logic            en_clear,
    input logic [NWIN-1:0] win_on,
    input logic            hit,
    input logic [2:0]      rgb,
    input logic            in_shadow
);

    AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rgb == 3'b000 && !in_shadow)); // R10

    AST_SHADOW_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_shadow |-> hit); // R5

    AST_CLEAR_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear |=> (win_on == '0)); // R8

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_load && !en_clear) |=> (win_on == $past(en_value))); // R9

    AST_ALL_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_on == '0) |=> !hit); // R1

endmodule

bind wincomp_top wincomp_chk #(.NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_load   (en_load),
    .en_value  (en_value),
    .en_clear  (en_clear),
    .win_on    (win_on),
    .hit       (hit),
    .rgb       (rgb),
    .in_shadow (in_shadow)
);

// File: tb/sim_wincomp_top.sv
`timescale 1ns/1ps
module sim_wincomp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_load = 1'b0, en_clear = 1'b0;
    logic [3:0]  en_value = '0;
    logic [4:0]  row_idx = '0, col_idx = '0;
    logic [3:0]  px_off = '0;
    logic [4:0]  ln_off = '0;
    logic [19:0] rs = '0, re = '0, cs = '0, ce = '0;
    logic [3:0]  shd_en = '0;
    logic [11:0] wcol = '0, scol = '0;
    logic [7:0]  wc = '0, hc = '0;
    logic        hit, in_shadow;
    logic [2:0]  rgb;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    wincomp_top u0 (
        .clk(clk), .rst_n(rst_n), .en_load(en_load), .en_value(en_value),
        .en_clear(en_clear), .row_idx(row_idx), .col_idx(col_idx),
        .px_off(px_off), .ln_off(ln_off), .win_row_start(rs), .win_row_end(re),
        .win_col_start(cs), .win_col_end(ce), .win_shd_en(shd_en),
        .win_color(wcol), .shd_wcode(wc), .shd_hcode(hc), .shd_color(scol),
        .hit(hit), .rgb(rgb), .in_shadow(in_shadow)
    );

    task automatic chk(string tag, logic eh, logic [2:0] ergb, logic es);
        n_chk++;
        if (hit !== eh || rgb !== ergb || in_shadow !== es) begin
            n_fail++;
            $display("FAIL %s: hit/rgb/shd got %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, hit, rgb, in_shadow, eh, ergb, es);
        end
    endtask

    task automatic set_win(int i, int r0, int r1, int c0, int c1, logic se,
                           int col, int w, int h, int sc);
        rs[i*5 +: 5] = 5'(r0); re[i*5 +: 5] = 5'(r1);
        cs[i*5 +: 5] = 5'(c0); ce[i*5 +: 5] = 5'(c1);
        shd_en[i] = se;
        wcol[i*3 +: 3] = 3'(col); scol[i*3 +: 3] = 3'(sc);
        wc[i*2 +: 2] = 2'(w); hc[i*2 +: 2] = 2'(h);
    endtask

    task automatic park_all();
        for (int i = 0; i < 4; i++) set_win(i, 1, 0, 1, 0, 1'b0, 0, 0, 0, 0);
    endtask

    task automatic load_en(logic [3:0] v, logic clr);
        en_value = v; en_load = 1'b1; en_clear = clr;
        @(negedge clk);
        en_load = 1'b0; en_clear = 1'b0;
    endtask

    // present a point, output is registered: read it one negedge later
    task automatic pix(int r, int c, int x, int y);
        row_idx = 5'(r); col_idx = 5'(c); px_off = 4'(x); ln_off = 5'(y);
        @(negedge clk);
    endtask

    task automatic t_reset();
        park_all();
        set_win(0, 2, 4, 3, 6, 1'b1, 5, 0, 0, 3);
        pix(3, 5, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        pix(3, 5, 0, 0);
        chk("R1 valid window not enabled", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_body();
        park_all();
        set_win(0, 2, 4, 3, 6, 1'b0, 5, 0, 0, 3);
        load_en(4'b0001, 1'b0);
        pix(3, 5, 0, 0);   chk("R2 interior", 1'b1, 3'd5, 1'b0);
        pix(2, 3, 0, 0);   chk("R2 top-left corner", 1'b1, 3'd5, 1'b0);
        pix(4, 6, 11, 17); chk("R2 bottom-right corner", 1'b1, 3'd5, 1'b0);
        pix(5, 6, 0, 0);   chk("R10 below window", 1'b0, 3'd0, 1'b0);
        pix(4, 7, 0, 0);   chk("R10 right of window", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_inverted();
        park_all();
        set_win(0, 4, 2, 3, 6, 1'b1, 5, 0, 0, 3);
        load_en(4'b0001, 1'b0);
        pix(3, 5, 0, 0); chk("R3 rows inverted", 1'b0, 3'd0, 1'b0);
        set_win(0, 2, 4, 6, 3, 1'b1, 5, 0, 0, 3);
        pix(3, 5, 0, 0); chk("R3 cols inverted body", 1'b0, 3'd0, 1'b0);
        pix(3, 7, 0, 0); chk("R3 cols inverted shadow", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_shadow();
        park_all();
        // body X 36..83 Y 36..89; codes 0 -> shadow X 38..85 Y 38..91
        set_win(0, 2, 4, 3, 6, 1'b1, 5, 0, 0, 3);
        load_en(4'b0001, 1'b0);
        pix(3, 7, 0, 0); chk("R5 right strip X84", 1'b1, 3'd3, 1'b1);
        pix(3, 7, 1, 0); chk("R6 width 2 last X85", 1'b1, 3'd3, 1'b1);
        pix(3, 7, 2, 0); chk("R6 width 2 past X86", 1'b0, 3'd0, 1'b0);
        pix(2, 7, 0, 1); chk("R5 top offset Y37", 1'b0, 3'd0, 1'b0);
        pix(2, 7, 0, 2); chk("R5 top offset Y38", 1'b1, 3'd3, 1'b1);
        pix(5, 3, 1, 0); chk("R5 left offset X37", 1'b0, 3'd0, 1'b0);
        pix(5, 3, 2, 0); chk("R5 bottom strip X38", 1'b1, 3'd3, 1'b1);
        pix(5, 4, 0, 2); chk("R6 height 2 past Y92", 1'b0, 3'd0, 1'b0);
        // codes w=3 (8 px), h=2 (6 lines): X 44..91 Y 42..95
        set_win(0, 2, 4, 3, 6, 1'b1, 5, 3, 2, 3);
        pix(3, 7, 7, 0); chk("R6 width 8 last X91", 1'b1, 3'd3, 1'b1);
        pix(3, 7, 8, 0); chk("R6 width 8 past X92", 1'b0, 3'd0, 1'b0);
        pix(5, 4, 0, 5); chk("R6 height 6 last Y95", 1'b1, 3'd3, 1'b1);
        pix(5, 4, 0, 6); chk("R6 height 6 past Y96", 1'b0, 3'd0, 1'b0);
        pix(5, 3, 7, 0); chk("R6 left offset X43", 1'b0, 3'd0, 1'b0);
        pix(5, 3, 8, 0); chk("R6 left offset X44", 1'b1, 3'd3, 1'b1);
    endtask

    task automatic t_shadow_off();
        park_all();
        set_win(0, 2, 4, 3, 6, 1'b0, 5, 0, 0, 3);
        load_en(4'b0001, 1'b0);
        pix(3, 7, 0, 0); chk("R7 right strip", 1'b0, 3'd0, 1'b0);
        pix(5, 4, 0, 0); chk("R7 bottom strip", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic set_overlap();
        park_all();
        set_win(0, 2, 4, 3, 6, 1'b1, 5, 0, 0, 3);
        set_win(1, 3, 8, 5, 10, 1'b0, 2, 0, 0, 7);
        set_win(2, 10, 12, 20, 25, 1'b0, 6, 0, 0, 0);
        set_win(3, 10, 12, 20, 25, 1'b0, 1, 0, 0, 0);
    endtask

    task automatic t_priority();
        set_overlap();
        load_en(4'b1111, 1'b0);
        pix(3, 5, 0, 0);   chk("R4 win1 over win2", 1'b1, 3'd5, 1'b0);
        pix(6, 8, 0, 0);   chk("R4 win2 alone", 1'b1, 3'd2, 1'b0);
        pix(8, 10, 11, 17); chk("R4 win2 corner", 1'b1, 3'd2, 1'b0);
        pix(3, 7, 0, 3);   chk("R4 win1 shadow over win2 body", 1'b1, 3'd3, 1'b1);
        pix(11, 22, 0, 0); chk("R4 win3 over win4", 1'b1, 3'd6, 1'b0);
    endtask

    task automatic t_clear();
        set_overlap();
        load_en(4'b1111, 1'b0);
        en_clear = 1'b1; @(negedge clk); en_clear = 1'b0;
        pix(11, 22, 0, 0); chk("R8 clear", 1'b0, 3'd0, 1'b0);
        load_en(4'b1111, 1'b1);
        pix(11, 22, 0, 0); chk("R8 clear beats load", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_load();
        set_overlap();
        load_en(4'b0100, 1'b0);
        pix(11, 22, 0, 0); chk("R9 only win3 on", 1'b1, 3'd6, 1'b0);
        pix(3, 5, 0, 0);   chk("R9 win1 win2 off", 1'b0, 3'd0, 1'b0);
        load_en(4'b1000, 1'b0);
        pix(11, 22, 0, 0); chk("R9 only win4 on", 1'b1, 3'd1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_body();
        t_inverted();
        t_shadow();
        t_shadow_off();
        t_priority();
        t_clear();
        t_load();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule